// File: doc/BRIEF.md
# Dual-Mode Display Memory Write Controller

This block takes 6-bit character codes from a processor bus and stores them in a small display memory, eight entries by default. A separate scan engine reads that memory through a combinational read port. The processor produces a write cycle with an active-low write input and two chip selects, one active high and one active low. The strobe counts as active only while all three are asserted. The block sees the start of that cycle when the combined strobe becomes active, and the end when it becomes inactive. All bus inputs pass through a synchronizer into the system clock first.

A mode input is captured at the start of each cycle and decides how the address pins are used. In random mode, the three address pins give the target location. In sequential mode, an internal counter gives the location. The counter begins at location 0 (the leftmost character) and advances by one after each accepted entry. In this mode address bit 0 is an enable input for chaining several devices, and address bit 1 is an active-low clear. A full flag stops further entries once every location has been filled. A busy output covers each write that will land, so the scan engine can blank the display during it.

Top module: `dispmem_wrctl`

## Requirements
- R1: A write cycle exists only while wr_n_i is 0, cs_i is 1 and cs_n_i is 0 together. Toggling wr_n_i while either chip select is inactive changes no memory location.
- R2: mode_i is captured at the start of a write cycle, with 1 meaning sequential and 0 meaning random. full_oe_o is 1 only while the captured mode is sequential and shutdown_i is 0.
- R3: In random mode, addr_i is captured at the start of the cycle and selects the location written. A change on addr_i later in the same cycle has no effect on that write. A random write does not move the sequential counter.
- R4: data_i is taken at the end of the write cycle, when the strobe becomes inactive, and stored whole at the selected location. A value present only earlier in the cycle is not stored.
- R5: In sequential mode with addr_i[0] (enable) captured as 1 and full_o at 0, the write goes to the counter's location. The counter is 0 after reset or clear and then steps by one per accepted write.
- R6: In sequential mode with addr_i[0] captured as 0, no location changes and the counter does not advance.
- R7: full_o goes to 1 once DEPTH sequential entries have been accepted. While it is 1, sequential writes change no location and the counter stays put.
- R8: While the captured mode is sequential, addr_i[1] at 0 immediately sets every location to the blank code 6'b100000 and returns the counter to 0, which also clears full_o. In random mode, addr_i[1] at 0 clears nothing.
- R9: While shutdown_i is 1, full_o is 0. The accepted count is kept, so full_o comes back when shutdown_i returns to 0.
- R10: busy_o is 1 from shortly after the start of a write that will land until its end. It stays 0 during sequential cycles that are disabled or that arrive while full.
- R11: After reset, every location reads 6'b100000, the captured mode is random, and full_o, full_oe_o and busy_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_n_i | input | 1 | Write strobe, active low |
| cs_i | input | 1 | Chip select, active high |
| cs_n_i | input | 1 | Chip select, active low |
| mode_i | input | 1 | Access mode: 1 sequential, 0 random |
| addr_i | input | 3 | Random: location. Sequential: bit 0 enable, bit 1 clear (active low) |
| data_i | input | 6 | Character code |
| shutdown_i | input | 1 | Low-power state; forces full_o inactive |
| full_o | output | 1 | All locations filled in sequential mode |
| full_oe_o | output | 1 | full_o is being driven (sequential mode, not shut down) |
| busy_o | output | 1 | A write that will land is in progress |
| rd_addr_i | input | 3 | Scan read location |
| rd_data_o | output | 6 | Code stored at rd_addr_i |

## Verification
A counter that slips or skips shows up at the ports on the very next accepted sequential write. That write lands one location away from where it should, and the read port shows it a few clocks after the strobe ends. A counter that fails to hold once full shows up when a later entry overwrites location 0, or as full_o dropping without a clear. A captured mode or address that is wrong shows up in full_oe_o as soon as the strobe start has been registered, or as data at the wrong location once the cycle closes. A clear that is gated wrongly shows up at once: rd_data_o either turns to blank, or fails to, within the same clock period that addr_i[1] falls.

// File: rtl/dispmem_pkg.sv
package dispmem_pkg;

   typedef enum logic {
      ACC_RANDOM = 1'b0,
      ACC_SEQ    = 1'b1
   } acc_mode_e;

   // Roles of address pins while the captured mode is sequential
   localparam int unsigned SEN_BIT = 0;
   localparam int unsigned CLR_BIT = 1;

   // Number of strobe-related pins carried through the synchronizer
   localparam int unsigned STRB_PINS = 3;

   typedef struct packed {
      logic wr_n;
      logic cs;
      logic cs_n;
   } strb_pins_t;

   localparam strb_pins_t STRB_IDLE = '{wr_n: 1'b1, cs: 1'b0, cs_n: 1'b1};

endpackage

// File: rtl/dispmem_sync.sv
module dispmem_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= RST_VAL;
            else        stg <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= {STAGES{RST_VAL}};
            else        stg <= {stg[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dispmem_rstsync.sv
module dispmem_rstsync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign srst_n = chain[STAGES-1];

endmodule

// File: rtl/dispmem_strobe_ctl.sv
module dispmem_strobe_ctl
   import dispmem_pkg::*;
#(
   parameter int unsigned AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strb_act,
   input  logic          mode_s,
   input  logic [AW-1:0] addr_s,
   input  logic          full,
   output acc_mode_e     mode_q,
   output logic [AW-1:0] addr_q,
   output logic          busy_q,
   output logic          we,
   output logic          inc
);

   logic strb_q;
   logic start;
   logic stop;
   logic qual_start;
   logic seq_ok;

   always_comb begin
      start = strb_act & ~strb_q;
      stop  = ~strb_act & strb_q;
   end

   // Does the cycle just begun lead to a memory write?
   always_comb begin
      if (acc_mode_e'(mode_s) == ACC_RANDOM) qual_start = 1'b1;
      else                                   qual_start = addr_s[SEN_BIT] & ~full;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_q <= 1'b0;
         mode_q <= ACC_RANDOM;
         addr_q <= '0;
         busy_q <= 1'b0;
      end else begin
         strb_q <= strb_act;
         if (start) begin
            mode_q <= acc_mode_e'(mode_s);
            addr_q <= addr_s;
            busy_q <= qual_start;
         end else if (stop) begin
            busy_q <= 1'b0;
         end
      end
   end

   always_comb begin
      seq_ok = addr_q[SEN_BIT] & ~full;
      we     = stop & busy_q & ((mode_q == ACC_RANDOM) | seq_ok);
      inc    = stop & busy_q & (mode_q == ACC_SEQ) & seq_ok;
   end

endmodule

// File: rtl/dispmem_seq_cnt.sv
module dispmem_seq_cnt #(
   parameter int unsigned DEPTH = 8
) (
   input  logic                         clk,
   input  logic                         clr_n,
   input  logic                         inc,
   output logic                         full,
   output logic [$clog2(DEPTH)-1:0]     loc,
   output logic [$clog2(DEPTH+1)-1:0]   cnt_o
);

   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] LAST = CW'(DEPTH);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)              cnt <= '0;
      else if (inc && !full)   cnt <= cnt + 1'b1;
   end

   assign full  = (cnt == LAST);
   assign loc   = cnt[AW-1:0];
   assign cnt_o = cnt;

endmodule

// File: rtl/dispmem_mem.sv
module dispmem_mem #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned CODE_W = 6,
   parameter logic [CODE_W-1:0] BLANK = '0
) (
   input  logic                     clk,
   input  logic                     clr_n,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] wa,
   input  logic [CODE_W-1:0]        wd,
   input  logic [$clog2(DEPTH)-1:0] ra,
   output logic [CODE_W-1:0]        rd
);

   localparam int unsigned AW = $clog2(DEPTH);

   logic [DEPTH-1:0][CODE_W-1:0] cells;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_row
         logic [CODE_W-1:0] row;
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n)                        row <= BLANK;
            else if (we && (wa == AW'(g)))     row <= wd;
         end
         assign cells[g] = row;
      end
   endgenerate

   assign rd = cells[ra];

endmodule

// File: rtl/dispmem_wrctl.sv
module dispmem_wrctl
   import dispmem_pkg::*;
#(
   parameter int unsigned DEPTH       = 8,
   parameter int unsigned CODE_W      = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_n_i,
   input  logic                     cs_i,
   input  logic                     cs_n_i,
   input  logic                     mode_i,
   input  logic [$clog2(DEPTH)-1:0] addr_i,
   input  logic [CODE_W-1:0]        data_i,
   input  logic                     shutdown_i,
   output logic                     full_o,
   output logic                     full_oe_o,
   output logic                     busy_o,
   input  logic [$clog2(DEPTH)-1:0] rd_addr_i,
   output logic [CODE_W-1:0]        rd_data_o
);

   localparam int unsigned AW      = $clog2(DEPTH);
   localparam int unsigned CW      = $clog2(DEPTH + 1);
   localparam int unsigned BUS_W   = STRB_PINS + 1 + AW + CODE_W;
   localparam int unsigned CLR_STG = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;
   localparam logic [CODE_W-1:0] BLANK = {1'b1, {(CODE_W-1){1'b0}}};
   localparam logic [BUS_W-1:0]  BUS_IDLE = {STRB_IDLE, {(1+AW+CODE_W){1'b0}}};

   // Elaboration-time parameter checks
   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("dispmem_wrctl: DEPTH must be a power of two of at least 4");
      end
      if (CODE_W < 2) begin : g_bad_code
         $error("dispmem_wrctl: CODE_W must be at least 2");
      end
   endgenerate

   // Bus synchronization
   logic [BUS_W-1:0] bus_raw;
   logic [BUS_W-1:0] bus_s;

   assign bus_raw = {wr_n_i, cs_i, cs_n_i, mode_i, addr_i, data_i};

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign bus_s = bus_raw;
      end else begin : g_sync
         dispmem_sync #(
            .W       (BUS_W),
            .STAGES  (SYNC_STAGES),
            .RST_VAL (BUS_IDLE)
         ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (bus_raw),
            .q     (bus_s)
         );
      end
   endgenerate

   strb_pins_t        pins_s;
   logic              mode_s;
   logic [AW-1:0]     addr_s;
   logic [CODE_W-1:0] data_s;
   logic              strb_act;

   assign {pins_s, mode_s, addr_s, data_s} = bus_s;
   assign strb_act = ~pins_s.wr_n & pins_s.cs & ~pins_s.cs_n;

   // Write cycle control
   acc_mode_e     mode_q;
   logic [AW-1:0] addr_q;
   logic          busy_q;
   logic          mem_we;
   logic          cnt_inc;
   logic          seq_full;
   logic [AW-1:0] seq_loc;
   logic [CW-1:0] seq_cnt;
   logic          mode_seq;

   dispmem_strobe_ctl #(
      .AW (AW)
   ) u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .strb_act (strb_act),
      .mode_s   (mode_s),
      .addr_s   (addr_s),
      .full     (seq_full),
      .mode_q   (mode_q),
      .addr_q   (addr_q),
      .busy_q   (busy_q),
      .we       (mem_we),
      .inc      (cnt_inc)
   );

   assign mode_seq = (mode_q == ACC_SEQ);

   // Clear: asserted at once from the pin, released through the clock
   logic clr_arst_n;
   logic clr_n;

   assign clr_arst_n = rst_n & ~(mode_seq & ~addr_i[CLR_BIT]);

   dispmem_rstsync #(
      .STAGES (CLR_STG)
   ) u_clr_sync (
      .clk    (clk),
      .arst_n (clr_arst_n),
      .srst_n (clr_n)
   );

   dispmem_seq_cnt #(
      .DEPTH (DEPTH)
   ) u_cnt (
      .clk   (clk),
      .clr_n (clr_n),
      .inc   (cnt_inc),
      .full  (seq_full),
      .loc   (seq_loc),
      .cnt_o (seq_cnt)
   );

   logic [AW-1:0] wr_loc;
   assign wr_loc = mode_seq ? seq_loc : addr_q;

   dispmem_mem #(
      .DEPTH  (DEPTH),
      .CODE_W (CODE_W),
      .BLANK  (BLANK)
   ) u_mem (
      .clk   (clk),
      .clr_n (clr_n),
      .we    (mem_we),
      .wa    (wr_loc),
      .wd    (data_s),
      .ra    (rd_addr_i),
      .rd    (rd_data_o)
   );

   assign full_oe_o = mode_seq & ~shutdown_i;
   assign full_o    = seq_full & mode_seq & ~shutdown_i;
   assign busy_o    = busy_q;

endmodule

// File: rtl/dispmem_wrctl_chk.sv
module dispmem_wrctl_chk #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned CODE_W = 6
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         clr_n,
   input logic [$clog2(DEPTH+1)-1:0]   cnt,
   input logic                         mem_we,
   input logic                         mode_seq,
   input logic [CODE_W-1:0]            rd_data
);

   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] LAST = CW'(DEPTH);
   localparam logic [CODE_W-1:0] BLANK = {1'b1, {(CODE_W-1){1'b0}}};

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!clr_n)
      cnt <= LAST); // R7

   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!clr_n)
      (cnt == LAST) |=> (cnt == LAST)); // R7

   AST_SEQ_STEP_ONE: assert property (@(posedge clk) disable iff (!clr_n)
      !$stable(cnt) |-> (cnt == $past(cnt) + 1'b1)); // R5

   AST_RAND_KEEPS_CNT: assert property (@(posedge clk) disable iff (!clr_n)
      (mem_we && !mode_seq) |=> $stable(cnt)); // R3

   AST_CLEAR_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> (rd_data == BLANK)); // R8

endmodule

bind dispmem_wrctl dispmem_wrctl_chk #(
   .DEPTH  (DEPTH),
   .CODE_W (CODE_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr_n    (clr_n),
   .cnt      (seq_cnt),
   .mem_we   (mem_we),
   .mode_seq (mode_seq),
   .rd_data  (rd_data_o)
);

// File: tb/test_dispmem_wrctl.sv
module test_dispmem_wrctl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_n_i = 1'b1;
   logic       cs_i = 1'b1;
   logic       cs_n_i = 1'b0;
   logic       mode_i = 1'b0;
   logic [2:0] addr_i = 3'b111;
   logic [5:0] data_i = 6'h00;
   logic       shutdown_i = 1'b0;
   logic       full_o;
   logic       full_oe_o;
   logic       busy_o;
   logic [2:0] rd_addr_i = 3'b000;
   logic [5:0] rd_data_o;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dispmem_wrctl i_dispmem_wrctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_n_i     (wr_n_i),
      .cs_i       (cs_i),
      .cs_n_i     (cs_n_i),
      .mode_i     (mode_i),
      .addr_i     (addr_i),
      .data_i     (data_i),
      .shutdown_i (shutdown_i),
      .full_o     (full_o),
      .full_oe_o  (full_oe_o),
      .busy_o     (busy_o),
      .rd_addr_i  (rd_addr_i),
      .rd_data_o  (rd_data_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
      end
   endtask

   task automatic rd_expect(input logic [2:0] loc, input logic [5:0] exp, input string tag);
      rd_addr_i = loc;
      #1;
      chk(rd_data_o == exp, tag, rd_data_o, exp);
   endtask

   // One write cycle; addr/data switch to a2/d2 halfway through
   task automatic pulse(input logic m, input logic [2:0] a, input logic [5:0] d,
                        input logic [2:0] a2, input logic [5:0] d2,
                        input logic cs, input logic csn, output logic busy_mid);
      @(negedge clk);
      mode_i = m; addr_i = a; data_i = d; cs_i = cs; cs_n_i = csn;
      @(negedge clk);
      wr_n_i = 1'b0;
      repeat (4) @(negedge clk);
      busy_mid = busy_o;
      addr_i = a2; data_i = d2;
      repeat (4) @(negedge clk);
      wr_n_i = 1'b1;
      repeat (5) @(negedge clk);
      addr_i = 3'b111; cs_i = 1'b1; cs_n_i = 1'b0;
   endtask

   task automatic t_reset;
      for (int i = 0; i < 8; i++) rd_expect(3'(i), 6'h20, "R11 blank after reset");
      chk(full_o == 1'b0, "R11 full_o after reset", full_o, 0);
      chk(full_oe_o == 1'b0, "R11 full_oe_o after reset", full_oe_o, 0);
      chk(busy_o == 1'b0, "R11 busy_o after reset", busy_o, 0);
   endtask

   task automatic t_random;
      logic b;
      pulse(1'b0, 3'b011, 6'h15, 3'b011, 6'h15, 1'b1, 1'b0, b);
      chk(b == 1'b1, "R10 busy during random write", b, 1);
      pulse(1'b0, 3'b101, 6'h2A, 3'b101, 6'h2A, 1'b1, 1'b0, b);
      rd_expect(3'd3, 6'h15, "R3 random write loc3");
      rd_expect(3'd5, 6'h2A, "R3 random write loc5");
      rd_expect(3'd0, 6'h20, "R3 untouched loc0");
      chk(busy_o == 1'b0, "R10 busy low after write", busy_o, 0);
      chk(full_oe_o == 1'b0, "R2 random mode not driving full", full_oe_o, 1'b0);
   endtask

   task automatic t_chipsel;
      logic b;
      pulse(1'b0, 3'b011, 6'h01, 3'b011, 6'h01, 1'b0, 1'b0, b);
      rd_expect(3'd3, 6'h15, "R1 cs_i inactive ignored");
      pulse(1'b0, 3'b011, 6'h02, 3'b011, 6'h02, 1'b1, 1'b1, b);
      rd_expect(3'd3, 6'h15, "R1 cs_n_i inactive ignored");
      chk(b == 1'b0, "R1 no busy without select", b, 0);
   endtask

   task automatic t_hold;
      logic b;
      pulse(1'b0, 3'b100, 6'h11, 3'b001, 6'h33, 1'b1, 1'b0, b);
      rd_expect(3'd4, 6'h33, "R4 data taken at end of cycle");
      rd_expect(3'd1, 6'h20, "R3 late address change ignored");
   endtask

   task automatic t_seq_fill;
      logic b;
      // enter sequential mode with enable low
      pulse(1'b1, 3'b110, 6'h07, 3'b110, 6'h07, 1'b1, 1'b0, b);
      chk(full_oe_o == 1'b1, "R2 sequential drives full", full_oe_o, 1);
      chk(b == 1'b0, "R10 no busy when disabled", b, 0);
      rd_expect(3'd3, 6'h15, "R6 disabled write changes nothing");
      rd_expect(3'd0, 6'h20, "R6 disabled write loc0");
      // clear
      @(negedge clk);
      addr_i = 3'b101;
      #1;
      rd_expect(3'd3, 6'h20, "R8 clear blanks loc3");
      rd_expect(3'd5, 6'h20, "R8 clear blanks loc5");
      @(negedge clk);
      addr_i = 3'b111;
      repeat (4) @(negedge clk);
      // disabled write again, counter must stay at 0
      pulse(1'b1, 3'b110, 6'h07, 3'b110, 6'h07, 1'b1, 1'b0, b);
      for (int i = 0; i < 8; i++) begin
         chk(full_o == 1'b0, "R7 full low before last entry", full_o, 0);
         pulse(1'b1, 3'b111, 6'(i + 1), 3'b111, 6'(i + 1), 1'b1, 1'b0, b);
      end
      for (int i = 0; i < 8; i++) rd_expect(3'(i), 6'(i + 1), "R5 sequential order");
      chk(full_o == 1'b1, "R7 full after eight entries", full_o, 1);
      // write while full
      pulse(1'b1, 3'b111, 6'h3F, 3'b111, 6'h3F, 1'b1, 1'b0, b);
      chk(b == 1'b0, "R10 no busy while full", b, 0);
      rd_expect(3'd0, 6'h01, "R7 full write ignored loc0");
      rd_expect(3'd7, 6'h08, "R7 full write ignored loc7");
      chk(full_o == 1'b1, "R7 full stays", full_o, 1);
   endtask

   task automatic t_shutdown;
      @(negedge clk);
      shutdown_i = 1'b1;
      #1;
      chk(full_o == 1'b0, "R9 full forced low in shutdown", full_o, 0);
      chk(full_oe_o == 1'b0, "R9 full not driven in shutdown", full_oe_o, 0);
      @(negedge clk);
      shutdown_i = 1'b0;
      #1;
      chk(full_o == 1'b1, "R9 full returns after shutdown", full_o, 1);
   endtask

   task automatic t_reclear;
      logic b;
      @(negedge clk);
      addr_i = 3'b101;
      #1;
      chk(full_o == 1'b0, "R8 clear drops full", full_o, 0);
      rd_expect(3'd7, 6'h20, "R8 clear blanks loc7");
      @(negedge clk);
      addr_i = 3'b111;
      repeat (4) @(negedge clk);
      pulse(1'b1, 3'b111, 6'h2C, 3'b111, 6'h2C, 1'b1, 1'b0, b);
      rd_expect(3'd0, 6'h2C, "R5 first entry after clear at loc0");
      rd_expect(3'd1, 6'h20, "R5 next location untouched");
   endtask

   task automatic t_rand_noclr;
      logic b;
      pulse(1'b0, 3'b110, 6'h19, 3'b110, 6'h19, 1'b1, 1'b0, b);
      rd_expect(3'd6, 6'h19, "R3 random write after mode change");
      chk(full_oe_o == 1'b0, "R2 back to random", full_oe_o, 0);
      @(negedge clk);
      addr_i = 3'b000;
      repeat (4) @(negedge clk);
      rd_expect(3'd0, 6'h2C, "R8 random mode ignores clear pin");
      rd_expect(3'd6, 6'h19, "R8 random mode keeps loc6");
      addr_i = 3'b111;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_random();
      t_chipsel();
      t_hold();
      t_seq_fill();
      t_shutdown();
      t_reclear();
      t_rand_noclr();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog act=0x0 exp=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule